// File: doc/BRIEF.md
# Global Interlock Lock Manager

This block arbitrates atomic read-modify-write sequences for a whole memory system. It keeps a single lock flag that covers all of memory, not one address or one module. Decoded commands arrive on a request port. An interlocked read that finds the lock free is accepted and takes the lock. An interlocked read that finds the lock taken is turned away with a retry response in the same cycle. A masked-write-unlock gives the lock back. Plain reads, writes and masked writes always pass and never touch the lock.

A hold timer guards against a lock owner that never releases. After a programmed number of cycles the lock is dropped by force and a sticky timeout flag is set. That flag drives an interrupt only while software enables it, and software clears it with a one-cycle strobe. An unlock that arrives when no lock is held is still carried out, but it leaves a sticky protocol-error flag.

Top module: `interlock_mgr`

## Requirements
- R1: After reset the lock is free, the timeout and protocol-error flags are low, the interrupt is low and there is no response on the request port.
- R2: Command codes are `req_cmd` 0 = read, 1 = write, 2 = masked write, 3 = interlocked read, 4 = masked-write-unlock; codes 5 to 7 behave as plain commands. An interlocked read that finds the lock free raises `req_accept` in the same cycle, and `lock_held` is high from the next cycle on.
- R3: An interlocked read that finds the lock held raises `req_retry` and not `req_accept` in the same cycle. It leaves the lock set and does not restart the hold timer.
- R4: A masked-write-unlock is always accepted in its own cycle, and `lock_held` is low from the next cycle on.
- R5: Plain commands (codes 0, 1, 2, 5, 6, 7) are accepted in their own cycle whether or not the lock is held, and they do not change the lock.
- R6: The lock stays held for exactly `tmo_limit` cycles after the cycle that took it. It is then cleared and `tmo_flag` is set on the same edge. A limit of 0 acts as 1.
- R7: `tmo_irq` is high only while `tmo_flag` and `tmo_irq_en` are both high. With the enable low the flag still sets.
- R8: A high `tmo_clr` clears `tmo_flag` on the next edge. If a timeout falls on that same edge, the flag stays set.
- R9: A masked-write-unlock that arrives while the lock is free is accepted and sets the sticky `proto_err` flag, which only reset clears.
- R10: A masked-write-unlock in the cycle in which the hold timer expires releases the lock as a normal unlock and leaves `tmo_flag` low.
- R11: With `req_valid` low, neither `req_accept` nor `req_retry` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command is present this cycle |
| req_cmd | input | 3 | Decoded command code |
| req_accept | output | 1 | Command taken this cycle |
| req_retry | output | 1 | Interlocked read refused, retry later |
| tmo_limit | input | CNT_W | Hold-time limit in cycles |
| tmo_irq_en | input | 1 | Enables the timeout interrupt |
| tmo_clr | input | 1 | Strobe that clears the timeout flag |
| lock_held | output | 1 | Lock is currently set |
| tmo_flag | output | 1 | Sticky timeout status |
| proto_err | output | 1 | Sticky unlock-without-lock status |
| tmo_irq | output | 1 | Timeout interrupt |

## Verification
Two functions can fall on the same edge. One case is a release by unlock and a forced release by the hold timer. The bench takes the lock with a short limit, counts idle cycles until the timer's final cycle, and issues the unlock in exactly that cycle. It then judges the result by `lock_held` low and `tmo_flag` still low. The other case is a timeout that coincides with the clear strobe. There the flag must stay high after the edge, and a later lone strobe must clear it.

// File: rtl/interlock_mgr.sv
module interlock_mgr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_cmd,
  output logic             req_accept,
  output logic             req_retry,
  input  logic [CNT_W-1:0] tmo_limit,
  input  logic             tmo_irq_en,
  input  logic             tmo_clr,
  output logic             lock_held,
  output logic             tmo_flag,
  output logic             proto_err,
  output logic             tmo_irq
);
  localparam logic [2:0] CMD_ILK_RD = 3'd3;
  localparam logic [2:0] CMD_UNLOCK = 3'd4;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             lock_q;
  logic [CNT_W-1:0] hold_cnt;
  logic [CNT_W-1:0] eff_limit;
  logic             is_ilk, is_unl, take, expire;

  assign is_ilk    = req_valid && (req_cmd == CMD_ILK_RD);
  assign is_unl    = req_valid && (req_cmd == CMD_UNLOCK);
  assign take      = is_ilk && !lock_q;
  assign req_retry = is_ilk && lock_q;
  assign req_accept = req_valid && !req_retry;
  assign eff_limit = (tmo_limit == '0) ? ONE : tmo_limit;
  assign expire    = lock_q && (hold_cnt >= eff_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      hold_cnt <= '0;
      tmo_flag <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (take) begin
        lock_q   <= 1'b1;
        hold_cnt <= ONE;
      end else if (is_unl) begin
        lock_q   <= 1'b0;
        hold_cnt <= '0;
      end else if (expire) begin
        lock_q   <= 1'b0;
        hold_cnt <= '0;
      end else if (lock_q) begin
        hold_cnt <= hold_cnt + ONE;
      end

      if (expire && !is_unl)
        tmo_flag <= 1'b1;
      else if (tmo_clr)
        tmo_flag <= 1'b0;

      if (is_unl && !lock_q)
        proto_err <= 1'b1;
    end
  end

  assign lock_held = lock_q;
  assign tmo_irq   = tmo_flag && tmo_irq_en;
endmodule

module interlock_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_cmd,
  input logic       req_accept,
  input logic       req_retry,
  input logic       lock_held,
  input logic       tmo_flag,
  input logic       proto_err
);
  // R2
  ilk_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 3'd3 && !lock_held) |=> lock_held);
  // R3
  ilk_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 3'd3 && lock_held) |-> (req_retry && !req_accept));
  // R4
  unlock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 3'd4) |=> !lock_held);
  // R5
  plain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_cmd inside {3'd0, 3'd1, 3'd2})) |-> req_accept);
  // R6
  tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $fell(lock_held));
  // R9
  proto_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd == 3'd4 && !lock_held) |=> proto_err);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!req_accept && !req_retry));
  // R3
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_accept, req_retry}));
endmodule

bind interlock_mgr interlock_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_accept(req_accept), .req_retry(req_retry), .lock_held(lock_held),
  .tmo_flag(tmo_flag), .proto_err(proto_err)
);

// File: tb/interlock_mgr_test.sv
module interlock_mgr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [15:0] tmo_limit = 16'd100;
  logic tmo_irq_en = 1'b0;
  logic tmo_clr = 1'b0;
  logic req_accept, req_retry, lock_held, tmo_flag, proto_err, tmo_irq;
  logic acc_s, rty_s;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  interlock_mgr #(.CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_accept(req_accept), .req_retry(req_retry), .tmo_limit(tmo_limit),
    .tmo_irq_en(tmo_irq_en), .tmo_clr(tmo_clr), .lock_held(lock_held),
    .tmo_flag(tmo_flag), .proto_err(proto_err), .tmo_irq(tmo_irq)
  );

  // {valid, cmd[2:0], exp_accept, exp_retry, exp_lock_after}
  localparam logic [6:0] VEC [12] = '{
    7'b0_000_000, 7'b1_000_100, 7'b1_001_100, 7'b1_011_101,
    7'b1_000_101, 7'b1_010_101, 7'b1_011_011, 7'b1_101_101,
    7'b1_100_100, 7'b1_011_101, 7'b1_011_011, 7'b1_100_100
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] c, input logic clr);
    req_valid = v;
    req_cmd   = c;
    tmo_clr   = clr;
    #1;
    acc_s = req_accept;
    rty_s = req_retry;
    @(negedge clk);
    req_valid = 1'b0;
    tmo_clr   = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 lock", lock_held, 1'b0);
    check("R1 tmo_flag", tmo_flag, 1'b0);
    check("R1 proto_err", proto_err, 1'b0);
    check("R1 irq", tmo_irq, 1'b0);
    #1;
    check("R1 accept", req_accept, 1'b0);
    check("R1 retry", req_retry, 1'b0);

    // Vector walk: R2 R3 R4 R5 R11
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][6], VEC[i][5:3], 1'b0);
      check("R2/R3/R5/R11 accept", acc_s, VEC[i][2]);
      check("R3/R11 retry", rty_s, VEC[i][1]);
      check("R2/R3/R4/R5 lock", lock_held, VEC[i][0]);
    end
    check("R9 no proto err on paired unlocks", proto_err, 1'b0);

    // R6 timeout after exactly 5 cycles, R7 irq enabled
    tmo_limit = 16'd5;
    tmo_irq_en = 1'b1;
    step(1'b1, 3'd3, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b0, 3'd0, 1'b0);
    check("R6 lock held before limit", lock_held, 1'b1);
    check("R6 flag low before limit", tmo_flag, 1'b0);
    step(1'b0, 3'd0, 1'b0);
    check("R6 lock forced clear", lock_held, 1'b0);
    check("R6 flag set", tmo_flag, 1'b1);
    check("R7 irq on", tmo_irq, 1'b1);
    tmo_irq_en = 1'b0;
    #1;
    check("R7 irq masked", tmo_irq, 1'b0);
    check("R7 flag kept when masked", tmo_flag, 1'b1);
    step(1'b0, 3'd0, 1'b1);
    check("R8 clear strobe", tmo_flag, 1'b0);

    // R3 refused read does not restart the timer (limit 4)
    tmo_limit = 16'd4;
    step(1'b1, 3'd3, 1'b0);
    step(1'b0, 3'd0, 1'b0);
    step(1'b1, 3'd3, 1'b0);
    check("R3 refused retry", rty_s, 1'b1);
    step(1'b0, 3'd0, 1'b0);
    check("R3 lock still held", lock_held, 1'b1);
    step(1'b0, 3'd0, 1'b0);
    check("R3 no timer restart", lock_held, 1'b0);
    check("R3 timeout flag", tmo_flag, 1'b1);

    // R8 timeout coinciding with clear strobe (limit 3)
    tmo_limit = 16'd3;
    step(1'b1, 3'd3, 1'b0);
    step(1'b0, 3'd0, 1'b0);
    step(1'b0, 3'd0, 1'b1);
    check("R8 clear during expiry lock", lock_held, 1'b1);
    step(1'b0, 3'd0, 1'b1);
    check("R8 set wins over clear", tmo_flag, 1'b1);
    check("R8 lock released", lock_held, 1'b0);
    step(1'b0, 3'd0, 1'b1);
    check("R8 lone clear", tmo_flag, 1'b0);

    // R10 unlock on expiry cycle (limit 3)
    step(1'b1, 3'd3, 1'b0);
    step(1'b0, 3'd0, 1'b0);
    step(1'b0, 3'd0, 1'b0);
    step(1'b1, 3'd4, 1'b0);
    check("R10 unlock accepted", acc_s, 1'b1);
    check("R10 lock released", lock_held, 1'b0);
    check("R10 no timeout flag", tmo_flag, 1'b0);
    check("R10 no proto err", proto_err, 1'b0);

    // R6 limit zero acts as one
    tmo_limit = 16'd0;
    step(1'b1, 3'd3, 1'b0);
    check("R6 limit0 taken", lock_held, 1'b1);
    step(1'b0, 3'd0, 1'b0);
    check("R6 limit0 released", lock_held, 1'b0);
    check("R6 limit0 flag", tmo_flag, 1'b1);

    // R9 unlock with lock free
    do_reset();
    tmo_limit = 16'd100;
    step(1'b1, 3'd4, 1'b0);
    check("R9 accepted", acc_s, 1'b1);
    check("R9 proto err set", proto_err, 1'b1);
    check("R9 lock free", lock_held, 1'b0);
    step(1'b0, 3'd0, 1'b1);
    check("R9 sticky", proto_err, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule